// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

The engine carries out one transfer cycle for a single channel in basic mode. A `start` strobe gives it a descriptor table base and a channel number. It then reads that channel's three live descriptor words through a single-port synchronous memory port. These words are the last source address, the last destination address and a packed control word. After that it copies items one by one: it reads the source and then writes the destination. The control word sets the item size and the address step on each side.

Items are grouped into bursts of 2^R. After each burst the engine writes the control word back with the remaining count reduced. If items are still outstanding, it waits for a `req` strobe before it continues. When the last item has been written and the write-back is done, `done` pulses for one cycle. A descriptor with an unusable mode or size ends the cycle at once with an `err` pulse. In that case no data is moved.

Top module: `desc_dma_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, `busy`, `done`, `err` and `mem_req` are low.
- R2: On `start` the engine reads three words, all with size code 2'b10. The reads are at D, D+4 and D+8 in that order, where D = `desc_base` + 16·`chan`. D holds the last source address, D+4 the last destination address and D+8 the control word.
- R3: Control word layout: destination step [31:30], destination size [29:28], source step [27:26], source size [25:24], burst exponent R [17:14], item count minus one [13:4], mode [2:0]. Step codes 0/1/2 advance by 1/2/4 bytes. Step code 3 keeps the address fixed at the last address. An item that has k items still to follow it uses address last − k·step.
- R4: Size codes 2'b00, 2'b01 and 2'b10 select byte, halfword and word items. Each item is a source read followed by a destination write. Reads carry the source size on `mem_size` and writes carry the destination size. The write data is the read data with the bits above the source size cleared.
- R5: After 2^R items the engine writes the updated control word to D+8 (size 2'b10). If items remain, it then issues no memory access until a request is seen. R values of 10 and above mean one burst for the whole cycle.
- R6: A `req` that arrives while the engine is busy but not waiting is kept pending. This includes the cycle of the burst write-back. A pending request lets the next burst start without a further strobe.
- R7: Each write-back holds the number of items still to move minus one in [13:4], and zero once the count is exhausted. All other control bits are unchanged.
- R8: `done` is high for exactly one cycle, in the cycle after the final write-back. In that cycle `busy` is already low.
- R9: A mode other than 3'b001, or a size code of 2'b11 on either side, ends the cycle right after the three descriptor reads. `err` pulses for one cycle, and no data access and no write-back take place.
- R10: A `start` while `busy` is high is ignored. The running cycle keeps its descriptor and its access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a cycle (taken only when idle) |
| req | input | 1 | Transfer request strobe for the next burst |
| desc_base | input | 32 | Descriptor table base address |
| chan | input | CHAN_W | Channel index into the table |
| busy | output | 1 | High while a cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle invalid-descriptor pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |

## Verification
Two functions can land in the same cycle: the burst-end write-back of the control word, and the arrival of a new transfer request. The bench provokes this by watching the ports. When it sees the write-back access in a cycle, it raises `req` in that same cycle. The run is judged by the scoreboard's full access sequence. The next burst's source read must follow the write-back directly, with no further strobe, and the cycle must end with one `done`. A lost request instead leaves the engine stalled, and the bench reports this as a failure.

// File: rtl/dma_desc_pkg.sv
`timescale 1ns/1ps
package dma_desc_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_FW = 10;
  localparam int LEFT_W = CNT_FW + 1;
  localparam int R_W    = 4;

  localparam logic [2:0] MODE_BASIC = 3'b001;
  localparam logic [1:0] INC_FIXED  = 2'b11;
  localparam logic [1:0] SZ_WORD    = 2'b10;
  localparam logic [1:0] SZ_NONE    = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FSRC, ST_FDST, ST_FCTL, ST_DECODE,
    ST_RD, ST_WR, ST_WB, ST_HOLD
  } eng_state_t;

  typedef struct packed {
    logic [1:0]        dinc;
    logic [1:0]        dsize;
    logic [1:0]        sinc;
    logic [1:0]        ssize;
    logic [5:0]        rsvd;
    logic [R_W-1:0]    r_exp;
    logic [CNT_FW-1:0] n_m1;
    logic              nxt_burst;
    logic [2:0]        mode;
  } ctl_word_t;

  // address of the item with (left-1) items after it
  function automatic logic [WORD_W-1:0] item_addr(input logic [WORD_W-1:0] end_ptr,
                                                  input logic [LEFT_W-1:0] left,
                                                  input logic [1:0]        inc);
    logic [WORD_W-1:0] back;
    back = WORD_W'(left - LEFT_W'(1));
    if (inc == INC_FIXED) item_addr = end_ptr;
    else                  item_addr = end_ptr - (back << inc);
  endfunction

  function automatic logic [LEFT_W-1:0] burst_len(input logic [R_W-1:0] r);
    if (r >= R_W'(CNT_FW)) burst_len = LEFT_W'(1) << CNT_FW;
    else                   burst_len = LEFT_W'(1) << r;
  endfunction

  function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz,
                                                  input logic [WORD_W-1:0] d);
    case (sz)
      2'b00:   size_mask = {24'd0, d[7:0]};
      2'b01:   size_mask = {16'd0, d[15:0]};
      default: size_mask = d;
    endcase
  endfunction

  function automatic logic desc_bad(input ctl_word_t c);
    desc_bad = (c.mode != MODE_BASIC) || (c.ssize == SZ_NONE) || (c.dsize == SZ_NONE);
  endfunction

  function automatic ctl_word_t wb_word(input ctl_word_t c, input logic [LEFT_W-1:0] left);
    ctl_word_t w;
    w = c;
    w.n_m1 = (left == '0) ? '0 : CNT_FW'(left - LEFT_W'(1));
    wb_word = w;
  endfunction
endpackage

// File: rtl/dma_burst_ctr.sv
`timescale 1ns/1ps
module dma_burst_ctr
  import dma_desc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [R_W-1:0] r_exp,
  input  logic           step,
  output logic           last
);
  logic [LEFT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     left_q <= '0;
    else if (load)                  left_q <= burst_len(r_exp);
    else if (step && left_q != '0)  left_q <= left_q - LEFT_W'(1);
  end

  assign last = (left_q == LEFT_W'(1));
endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
module dma_addr_gen
  import dma_desc_pkg::*;
(
  input  logic [WORD_W-1:0] end_ptr,
  input  logic [LEFT_W-1:0] left,
  input  logic [1:0]        inc,
  output logic [WORD_W-1:0] addr
);
  assign addr = item_addr(end_ptr, left, inc);
endmodule

// File: rtl/desc_dma_engine.sv
`timescale 1ns/1ps
module desc_dma_engine
  import dma_desc_pkg::*;
#(
  parameter int CHAN_W     = 5,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req,
  input  logic [31:0]       desc_base,
  input  logic [CHAN_W-1:0] chan,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int DESC_SH = $clog2(DESC_BYTES);
  localparam int N_SIDES = 2;   // 0 = source, 1 = destination

  eng_state_t        state_q;
  logic [WORD_W-1:0] desc_q, src_end_q, dst_end_q;
  ctl_word_t         ctl_q, ctl_in;
  logic [LEFT_W-1:0] left_q;
  logic              pend_q, done_q, err_q;

  // named internal events
  logic in_hold_w, go_w, burst_last_w, item_last_w, burst_load_w;
  logic [R_W-1:0] burst_r_w;

  assign ctl_in       = ctl_word_t'(mem_rdata);
  assign in_hold_w    = (state_q == ST_HOLD);
  assign go_w         = req || pend_q;
  assign item_last_w  = (left_q == LEFT_W'(1));
  assign burst_load_w = ((state_q == ST_DECODE) && !desc_bad(ctl_in)) || (in_hold_w && go_w);
  assign burst_r_w    = (state_q == ST_DECODE) ? ctl_in.r_exp : ctl_q.r_exp;

  dma_burst_ctr u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (burst_load_w),
    .r_exp (burst_r_w),
    .step  (state_q == ST_WR),
    .last  (burst_last_w)
  );

  logic [WORD_W-1:0] side_end [N_SIDES];
  logic [1:0]        side_inc [N_SIDES];
  logic [WORD_W-1:0] side_addr[N_SIDES];

  assign side_end[0] = src_end_q;
  assign side_end[1] = dst_end_q;
  assign side_inc[0] = ctl_q.sinc;
  assign side_inc[1] = ctl_q.dinc;

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    dma_addr_gen u_agen (
      .end_ptr (side_end[g]),
      .left    (left_q),
      .inc     (side_inc[g]),
      .addr    (side_addr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      desc_q    <= '0;
      src_end_q <= '0;
      dst_end_q <= '0;
      ctl_q     <= '0;
      left_q    <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (in_hold_w)                       pend_q <= 1'b0;
      else if (req && state_q != ST_IDLE)  pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (start) begin
          desc_q  <= desc_base + (WORD_W'(chan) << DESC_SH);
          pend_q  <= 1'b0;
          state_q <= ST_FSRC;
        end
        ST_FSRC: state_q <= ST_FDST;
        ST_FDST: begin
          src_end_q <= mem_rdata;
          state_q   <= ST_FCTL;
        end
        ST_FCTL: begin
          dst_end_q <= mem_rdata;
          state_q   <= ST_DECODE;
        end
        ST_DECODE: begin
          ctl_q <= ctl_in;
          if (desc_bad(ctl_in)) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            left_q  <= LEFT_W'(ctl_in.n_m1) + LEFT_W'(1);
            state_q <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          left_q  <= left_q - LEFT_W'(1);
          state_q <= (item_last_w || burst_last_w) ? ST_WB : ST_RD;
        end
        ST_WB: begin
          if (left_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: if (go_w) state_q <= ST_RD;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_size  = SZ_WORD;
    mem_wdata = '0;
    case (state_q)
      ST_FSRC: begin mem_req = 1'b1; mem_addr = desc_q; end
      ST_FDST: begin mem_req = 1'b1; mem_addr = desc_q + 32'd4; end
      ST_FCTL: begin mem_req = 1'b1; mem_addr = desc_q + 32'd8; end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = side_addr[0];
        mem_size = ctl_q.ssize;
      end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = side_addr[1];
        mem_size  = ctl_q.dsize;
        mem_wdata = size_mask(ctl_q.ssize, mem_rdata);
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_q + 32'd8;
        mem_wdata = wb_word(ctl_q, left_q);
      end
      default: ;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/dma_engine_chk.sv
`timescale 1ns/1ps
module dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        in_hold
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R5
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> (busy && !mem_req));

  // R7
  wb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_we && (mem_wdata[13:4] == 10'd0)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done) ##1 !err);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind desc_dma_engine dma_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .in_hold   (in_hold_w)
);

// File: tb/desc_dma_engine_bench.sv
`timescale 1ns/1ps
module desc_dma_engine_bench;
  localparam int CHAN_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req = 1'b0;
  logic [31:0] desc_base = '0;
  logic [CHAN_W-1:0] chan = '0;
  logic busy, done, err, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_size;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  desc_dma_engine #(.CHAN_W(CHAN_W)) u_desc_dma_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req),
    .desc_base(desc_base), .chan(chan),
    .busy(busy), .done(done), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // ---------------- memory model ----------------
  logic [7:0]  mem [0:4095];
  logic        pk_en = 1'b0;
  logic [31:0] pk_addr = '0, pk_data = '0;

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (pk_en) begin
      for (int k = 0; k < 4; k++) mem[12'(pk_addr + 32'(k))] <= pk_data[8*k +: 8];
    end else if (mem_req && mem_we) begin
      for (int k = 0; k < nbytes(mem_size); k++) mem[12'(mem_addr + 32'(k))] <= mem_wdata[8*k +: 8];
    end
    if (mem_req && !mem_we)
      mem_rdata <= {mem[12'(mem_addr + 32'd3)], mem[12'(mem_addr + 32'd2)],
                    mem[12'(mem_addr + 32'd1)], mem[12'(mem_addr)]};
  end

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h3};
  endfunction

  function automatic logic [31:0] pat_item(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = pat(a + 32'(k));
    return v;
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
  } acc_t;

  acc_t  exp_q[$];
  string cur_req = "R1";
  int    mon_total = 0, mon_bad = 0;
  int    chk_total = 0, chk_bad = 0;
  int    done_seen = 0, err_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_seen++;
      if (err)  err_seen++;
      if (mem_req) begin
        mon_total++;
        if (exp_q.size() == 0) begin
          mon_bad++;
          $display("FAIL %s unexpected access actual=we%0b addr=%h expected=none", cur_req, mem_we, mem_addr);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          if (mem_we !== e.we || mem_addr !== e.addr || mem_size !== e.size ||
              (e.we && mem_wdata !== e.data)) begin
            mon_bad++;
            $display("FAIL %s access actual=we%0b a=%h s=%0d d=%h expected=we%0b a=%h s=%0d d=%h",
                     cur_req, mem_we, mem_addr, mem_size, mem_wdata, e.we, e.addr, e.size, e.data);
          end
        end
      end
    end
  end

  // ---------------- request generator ----------------
  int          rmode = 2;
  logic [31:0] wb_addr_v = '0;
  int          quiet = 0;

  always @(negedge clk) begin
    case (rmode)
      0: req = mem_req && mem_we && (mem_addr == wb_addr_v);      // same cycle as write-back
      1: req = mem_req && mem_we && (mem_addr != wb_addr_v);      // during the burst
      default: begin
        if (busy && !mem_req) quiet++; else quiet = 0;
        req = (quiet == 3);
        if (req) quiet = 0;
      end
    endcase
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", mon_total + chk_total + 1, mon_bad + chk_bad + 1);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic check(input bit ok, input string rq, input string what, input int act, input int expv);
    chk_total++;
    if (!ok) begin
      chk_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  task automatic poke32(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pk_en = 1'b1; pk_addr = a; pk_data = d;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic run_case(input string rq, input int base, input int ch,
                          input logic [31:0] src_end, input logic [31:0] dst_end,
                          input int sinc, input int ssize, input int dinc, input int dsize,
                          input int r, input int nm1, input int mode, input int rm,
                          input bit mid_start);
    logic [31:0] d, ctl, wbw;
    bit          bad_desc;
    int          left, blen, d0, e0, guard, sstp, dstp;
    acc_t        a;
    d   = 32'(base) + 32'(ch) * 32'd16;
    ctl = {dinc[1:0], dsize[1:0], sinc[1:0], ssize[1:0], 6'd0, r[3:0], nm1[9:0], 1'b0, mode[2:0]};
    poke32(d, src_end);
    poke32(d + 4, dst_end);
    poke32(d + 8, ctl);
    poke32(d + 12, 32'd0);
    cur_req = rq;
    rmode = rm;
    wb_addr_v = d + 8;
    // R2: descriptor fetch order
    for (int k = 0; k < 3; k++) begin
      a.we = 0; a.addr = d + 32'(4 * k); a.size = 2'b10; a.data = '0;
      exp_q.push_back(a);
    end
    bad_desc = (mode != 1) || (ssize == 3) || (dsize == 3);
    if (!bad_desc) begin
      sstp = (sinc == 3) ? 0 : (sinc == 0) ? 1 : (sinc == 1) ? 2 : 4;
      dstp = (dinc == 3) ? 0 : (dinc == 0) ? 1 : (dinc == 1) ? 2 : 4;
      blen = (r >= 10) ? 1024 : (1 << r);
      left = nm1 + 1;
      while (left > 0) begin
        for (int j = 0; j < blen && left > 0; j++) begin
          logic [31:0] sa;
          sa = src_end - 32'((left - 1) * sstp);
          a.we = 0; a.addr = sa; a.size = ssize[1:0]; a.data = '0;
          exp_q.push_back(a);
          a.we = 1; a.addr = dst_end - 32'((left - 1) * dstp); a.size = dsize[1:0];
          a.data = pat_item(sa, ssize[1:0]);
          exp_q.push_back(a);
          left--;
        end
        wbw = ctl;
        wbw[13:4] = (left == 0) ? 10'd0 : 10'(left - 1);
        a.we = 1; a.addr = d + 8; a.size = 2'b10; a.data = wbw;
        exp_q.push_back(a);
      end
    end
    d0 = done_seen; e0 = err_seen;
    @(negedge clk);
    desc_base = 32'(base); chan = CHAN_W'(ch); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (mid_start && guard == 6) begin
        desc_base = 32'h0; chan = '0; start = 1'b1;   // R10: must be ignored
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy, rq, "engine still busy", int'(busy), 0);
    check(exp_q.size() == 0, rq, "accesses missing", exp_q.size(), 0);
    check(done_seen - d0 == (bad_desc ? 0 : 1), bad_desc ? "R9" : "R8", "done pulses", done_seen - d0, bad_desc ? 0 : 1);
    check(err_seen - e0 == (bad_desc ? 1 : 0), "R9", "err pulses", err_seen - e0, bad_desc ? 1 : 0);
    exp_q.delete();
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !err && !mem_req, "R1", "outputs in reset", int'({busy, done, err, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req, "R1", "idle after reset", int'({busy, mem_req}), 0);
    for (int a = 32'h800; a < 32'hC00; a += 4)
      poke32(a, {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)});

    // R3 R4 R5: halfword source stepping, fixed destination, bursts 4,4,2
    run_case("R3", 32'h400, 3, 32'h812, 32'hF00, 1, 1, 3, 1, 2, 9, 1, 2, 1'b0);
    // R6: request raised in the write-back cycle, byte items, bursts 2,2,1
    run_case("R6", 32'h400, 0, 32'h904, 32'hC04, 0, 0, 0, 0, 1, 4, 1, 0, 1'b0);
    // R4 R7: word items, single burst, requests during the burst
    run_case("R4", 32'h400, 1, 32'hA14, 32'hC94, 2, 2, 2, 2, 4, 5, 1, 1, 1'b0);
    // R7: one-item cycle
    run_case("R7", 32'h400, 2, 32'h840, 32'hD00, 1, 1, 1, 1, 0, 0, 1, 2, 1'b0);
    // R5: R above the count width gives one burst; byte source into halfword destination
    run_case("R5", 32'h400, 4, 32'h973, 32'hD66, 0, 0, 1, 1, 12, 19, 1, 2, 1'b0);
    // R9: invalid mode 000, mode 010, reserved size
    run_case("R9", 32'h400, 5, 32'h900, 32'hE00, 0, 0, 0, 0, 0, 3, 0, 2, 1'b0);
    run_case("R9", 32'h400, 6, 32'h900, 32'hE00, 0, 0, 0, 0, 0, 3, 2, 2, 1'b0);
    run_case("R9", 32'h400, 7, 32'h900, 32'hE00, 0, 3, 0, 0, 0, 3, 1, 2, 1'b0);
    // R10: start while busy is ignored
    run_case("R10", 32'h400, 8, 32'h812, 32'hF00, 1, 1, 3, 1, 2, 9, 1, 2, 1'b1);
    // R2: back to back from a second table base
    run_case("R2", 32'h200, 1, 32'hB08, 32'hE40, 2, 2, 2, 2, 1, 2, 1, 2, 1'b0);

    $display("test done: total=%0d bad=%0d", mon_total + chk_total, mon_bad + chk_bad);
    $finish;
  end
endmodule